// File: doc/BRIEF.md
# UART RTS/CTS Flow-Control Unit

This unit adds hardware flow control to one serial channel. The channel's request-to-send line is one bit of an eight-bit general output port. When receiver-driven RTS is enabled, the unit negates RTS on its own at the moment the receive holding buffer becomes full. It never re-asserts RTS by itself. Software raises it again with a set-port command, usually when it services the interrupt that comes from the falling edge of the buffer-full status output.

On the transmit side, the unit can hold back the start of each character while the clear-to-send input is negated. CTS is asynchronous, so it passes through a two-stage synchroniser before use. Starts use a valid/ready handshake. The transmitter raises `tx_start_valid` when it has a character to begin, and the character starts in a cycle where `tx_start_valid` and `tx_start_ready` are both high. While `tx_start_ready` is low the transmitter keeps its request pending and does not start. `tx_start_ready` does not depend on `tx_start_valid`. A character that has already started is outside this handshake, so it always runs to completion.

Software reaches the unit through a plain write bus with address, data and strobe. The bus carries mode writes and output-port set and clear commands.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset the port register holds zero, so `op_n` reads 0xFF. `full_stat` is 0, and both mode enables are clear.
- R2: A write to address 0xE sets each port register bit whose data bit is 1 and leaves the other bits unchanged. Every pin `op_n[k]` drives the complement of register bit k, and the pins change in the cycle after the write.
- R3: A write to address 0xF clears each port register bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A write to address 0x0 loads the auto-RTS enable from data bit 7. While that enable is set, a rising edge on `rx_full` clears register bit 0. As a result, `op_n[0]` (the RTS pin) reads 1 in the cycle after `rx_full` is first seen high.
- R5: Once RTS has been negated by the full event, a fall of `rx_full` does not re-assert it. `op_n[0]` stays 1 until a set write to 0xE with data bit 0 equal to 1.
- R6: If a set write and a full rising edge fall in the same cycle, bit 0 ends up cleared. The other set bits still take effect.
- R7: After software re-asserts RTS, the next rising edge of `rx_full` negates it again.
- R8: `full_stat` equals `rx_full` delayed by one clock, so it is high while the buffer is full. Its falling edge serves as the interrupt source.
- R9: A write to address 0x1 loads the CTS enable from data bit 4. While that enable is set, `tx_start_ready` follows the complement of `cts_n` two clocks later, because of the two-stage synchroniser. The ready signal is low while CTS is negated.
- R10: While the CTS enable is clear, `tx_start_ready` is 1 whatever the level of `cts_n`.
- R11: While the auto-RTS enable is clear, `rx_full` has no effect on `op_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rx_full | input | 1 | Receive holding buffer full |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_start_valid | input | 1 | Transmitter wants to start a character |
| tx_start_ready | output | 1 | Character start permitted |
| op_n | output | 8 | Output-port pins (bit 0 is RTS, active low) |
| full_stat | output | 1 | Buffer-full status |

## Verification
The hardest case to reach is a set-port write that lands on the same clock edge as the buffer-full rise. Reaching it needs `rx_full` low for at least one cycle first, so that a fresh edge exists, and then the write strobe and the flag driven together in a single cycle. The bench does this with one combined stimulus step. It checks that RTS stays negated while the other set bits still take effect. The no-automatic-re-assert rule is then checked by holding the flag low for several idle cycles after the buffer empties.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int ADDR_MODE1 = 0;
  localparam int ADDR_MODE2 = 1;
  localparam int ADDR_SET   = 14;
  localparam int ADDR_CLR   = 15;
  localparam int AUTO_RTS_BIT = 7;
  localparam int CTS_EN_BIT   = 4;
  localparam int RTS_PIN      = 0;
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b1;
        else        q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/flow_mode_regs.sv
module flow_mode_regs
  import flow_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              auto_rts_en,
  output logic              cts_en
);
  logic hit_m1, hit_m2;
  assign hit_m1 = wr_en && (wr_addr == ADDR_W'(ADDR_MODE1));
  assign hit_m2 = wr_en && (wr_addr == ADDR_W'(ADDR_MODE2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_rts_en <= 1'b0;
      cts_en      <= 1'b0;
    end else begin
      if (hit_m1) auto_rts_en <= wr_data[AUTO_RTS_BIT];
      if (hit_m2) cts_en      <= wr_data[CTS_EN_BIT];
    end
  end
endmodule

// File: rtl/flow_port_reg.sv
module flow_port_reg
  import flow_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] set_mask,
  input  logic [PORT_W-1:0] clr_mask,
  input  logic              rx_full,
  input  logic              auto_rts_en,
  output logic              full_q,
  output logic [PORT_W-1:0] port_q
);
  logic              full_rise;
  logic [PORT_W-1:0] port_nxt;

  assign full_rise = rx_full && !full_q;

  always_comb begin
    port_nxt = (port_q | set_mask) & ~clr_mask;
    if (auto_rts_en && full_rise) port_nxt[RTS_PIN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      full_q <= 1'b0;
    end else begin
      port_q <= port_nxt;
      full_q <= rx_full;
    end
  end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import flow_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rx_full,
  input  logic              cts_n,
  input  logic              tx_start_valid,
  output logic              tx_start_ready,
  output logic [PORT_W-1:0] op_n,
  output logic              full_stat
);
  logic              auto_rts_en, cts_en, cts_sync_n, full_q;
  logic [PORT_W-1:0] set_mask, clr_mask, port_q;

  assign set_mask = (wr_en && wr_addr == ADDR_W'(ADDR_SET)) ? wr_data : '0;
  assign clr_mask = (wr_en && wr_addr == ADDR_W'(ADDR_CLR)) ? wr_data : '0;

  flow_mode_regs #(.ADDR_W(ADDR_W), .DATA_W(PORT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .auto_rts_en(auto_rts_en), .cts_en(cts_en)
  );

  flow_port_reg #(.PORT_W(PORT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .rx_full(rx_full), .auto_rts_en(auto_rts_en), .full_q(full_q),
    .port_q(port_q)
  );

  flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cts_n), .dout(cts_sync_n)
  );

  // Ready is independent of valid; a start occurs on valid && ready.
  assign tx_start_ready = !cts_en || !cts_sync_n;
  assign op_n           = ~port_q;
  assign full_stat      = full_q;

  logic unused_valid;
  assign unused_valid = tx_start_valid;
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
module uart_flow_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PORT_W-1:0] wr_data,
  input logic              rx_full,
  input logic              cts_n,
  input logic              tx_start_ready,
  input logic [PORT_W-1:0] op_n,
  input logic              full_stat,
  input logic              auto_rts_en,
  input logic              cts_en
);
  logic set_w, clr_w;
  assign set_w = wr_en && wr_addr == ADDR_W'(14);
  assign clr_w = wr_en && wr_addr == ADDR_W'(15);

  // R4
  auto_negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_full && !full_stat) |=> op_n[0]);

  // R5
  no_self_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_n[0] && !(set_w && wr_data[0])) |=> op_n[0]);

  // R2
  set_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> ((~op_n[PORT_W-1:1] & $past(wr_data[PORT_W-1:1])) == $past(wr_data[PORT_W-1:1])));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ((op_n & $past(wr_data)) == $past(wr_data)));

  // R8
  full_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (full_stat == $past(rx_full)));

  // R9
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && $past(cts_n, 2)) |-> !tx_start_ready);

  // R10
  cts_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_en |-> tx_start_ready);

  // R11
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_rts_en && !op_n[0] && !clr_w) |=> !op_n[0]);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rx_full(rx_full), .cts_n(cts_n),
  .tx_start_ready(tx_start_ready), .op_n(op_n), .full_stat(full_stat),
  .auto_rts_en(auto_rts_en), .cts_en(cts_en)
);

// File: tb/uart_flow_ctrl_test.sv
`timescale 1ns/1ps
module uart_flow_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rx_full = 1'b0;
  logic       cts_n = 1'b1;
  logic       tx_start_valid = 1'b1;
  logic       tx_start_ready;
  logic [7:0] op_n;
  logic       full_stat;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  uart_flow_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_full(rx_full), .cts_n(cts_n),
    .tx_start_valid(tx_start_valid), .tx_start_ready(tx_start_ready),
    .op_n(op_n), .full_stat(full_stat)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    check("R1 op_n", op_n, 8'hFF);
    check("R1 full_stat", {7'b0, full_stat}, 8'h00);
    check("R10 ready after reset", {7'b0, tx_start_ready}, 8'h01);
  endtask

  task automatic t_set_clr;
    bus_write(4'hE, 8'hA5);
    check("R2 set A5", op_n, 8'h5A);
    bus_write(4'hE, 8'h02);
    check("R2 set keeps zero bits", op_n, 8'h58);
    bus_write(4'hF, 8'h81);
    check("R3 clear 81", op_n, 8'hD9);
    bus_write(4'hF, 8'hFF);
    check("R3 clear all", op_n, 8'hFF);
  endtask

  task automatic t_auto_off;
    bus_write(4'hE, 8'h01);
    check("R11 rts asserted", op_n, 8'hFE);
    rx_full = 1'b1; @(negedge clk);
    check("R11 full ignored", op_n, 8'hFE);
    check("R8 full_stat high", {7'b0, full_stat}, 8'h01);
    rx_full = 1'b0; @(negedge clk);
    check("R8 full_stat low", {7'b0, full_stat}, 8'h00);
    bus_write(4'hF, 8'h01);
  endtask

  task automatic t_auto_on;
    bus_write(4'h0, 8'h80);
    bus_write(4'hE, 8'h01);
    check("R4 rts asserted", op_n, 8'hFE);
    rx_full = 1'b1; @(negedge clk);
    check("R4 auto negate", op_n, 8'hFF);
    idle(3);
    rx_full = 1'b0; @(negedge clk);
    check("R8 falling edge", {7'b0, full_stat}, 8'h00);
    idle(5);
    check("R5 no auto reassert", op_n, 8'hFF);
    bus_write(4'hE, 8'h01);
    check("R5 software reassert", op_n, 8'hFE);
    rx_full = 1'b1; @(negedge clk);
    check("R7 negate again", op_n, 8'hFF);
    rx_full = 1'b0; idle(2);
  endtask

  task automatic t_collide;
    wr_en = 1'b1; wr_addr = 4'hE; wr_data = 8'h03; rx_full = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check("R6 full wins over set", op_n, 8'hFD);
    rx_full = 1'b0; idle(2);
    bus_write(4'hF, 8'hFF);
    bus_write(4'h0, 8'h00);
  endtask

  task automatic t_cts;
    cts_n = 1'b1; idle(3);
    check("R10 cts ignored", {7'b0, tx_start_ready}, 8'h01);
    bus_write(4'h1, 8'h10);
    check("R9 held while negated", {7'b0, tx_start_ready}, 8'h00);
    cts_n = 1'b0; @(negedge clk);
    check("R9 one stage", {7'b0, tx_start_ready}, 8'h00);
    @(negedge clk);
    check("R9 released", {7'b0, tx_start_ready}, 8'h01);
    cts_n = 1'b1; @(negedge clk);
    check("R9 still open", {7'b0, tx_start_ready}, 8'h01);
    @(negedge clk);
    check("R9 held again", {7'b0, tx_start_ready}, 8'h00);
    bus_write(4'h1, 8'h00);
    check("R10 disabled again", {7'b0, tx_start_ready}, 8'h01);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clr();
    t_auto_off();
    t_auto_on();
    t_collide();
    t_cts();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule